// File: doc/BRIEF.md
# QVGA Panel Sync and Enable Generator

This block produces the raster timing for a 320x240 panel with 18-bit colour. It runs on the pixel clock and has an asynchronous active-low reset. A free-running cycle counter sweeps each line. A line counter steps once per line and restarts after the last line of the frame. From these two counters the block drives an active-low horizontal sync, an active-low vertical sync and a data-enable strobe. The strobe marks the pixels of every visible line.

Both counters are brought out next to the strobes. The three strobes are registered so that they line up with the counter values shown in the same cycle. A separate pixel source can therefore fetch colour data in step with the enable. Three static pins report the scan orientation and the resolution mode; only the QVGA mode may be selected. Every timing value is a parameter. A value outside the panel's legal window stops elaboration with an error. The enable window must also fit inside one line, and the visible lines must fit inside one frame.

Top module: `qvga_panel_timing`

## Requirements
- R1: While reset is low, both sync outputs are 1 and the enable is 0. The counters hold their last position: cycle H_PERIOD-1 (399) and line V_PERIOD-1 (254). The first clock edge after release moves the block to cycle 0 of line 0.
- R2: The cycle count steps by one on each clock, from 0 to H_PERIOD-1 (default 400 clocks per line), and then wraps to 0. Falling edges of the horizontal sync are exactly H_PERIOD clocks apart.
- R3: The line count advances by one in the cycle where the cycle count wraps to 0. It runs from 0 to V_PERIOD-1 (default 255 lines) and then returns to 0.
- R4: The horizontal sync is 0 exactly while the cycle count is below H_PULSE (default 10 clocks), and 1 at all other times.
- R5: The vertical sync is 0 for every cycle of lines 0 to V_PULSE-1 (default 3 lines), and 1 on all other lines.
- R6: On a visible line, the enable is 1 exactly while the cycle count lies in EN_DELAY..EN_DELAY+EN_WIDTH-1. With the defaults this is cycles 8..327: the strobe starts 8 clocks after the sync falls and lasts 320 clocks.
- R7: The enable is 0 on every line outside V_START..V_START+ACTIVE_LINES-1. V_START is fixed at 7, so the first enabled line is the eighth line of the frame. Each frame has ACTIVE_LINES (default 240) enabled lines.
- R8: The static pins read mirrorH = 0, flipV = 1 and vgaMode = 0, both during reset and in normal running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| dataEn | output | 1 | Enable strobe for visible pixels |
| lineNum | output | LINE_W (9) | Current line within the frame |
| cycNum | output | CNT_W (9) | Current pixel-clock cycle within the line |
| mirrorH | output | 1 | Static right/left scan direction |
| flipV | output | 1 | Static up/down scan direction |
| vgaMode | output | 1 | Static resolution select, 0 = QVGA |

## Verification
The properties assume that the clock runs without gaps. They also assume that reset is the only input able to disturb the raster, so the counter relations must hold in every cycle outside reset, including the first edge after release. The stimulus therefore varies only when reset is applied. Reset is raised once at the start and once more at a random point in mid-line, held for a random few cycles, and the block is then run for more than one complete frame. Every raster edge, wrap and window boundary is visited under these parameter defaults.

// File: rtl/qvga_timing_pkg.sv
package qvga_timing_pkg;

  // Window flags for the position the raster enters on the next edge
  typedef struct packed {
    logic hsyncAct;
    logic vsyncAct;
    logic colAct;
    logic rowAct;
  } scanStrobes_t;

endpackage

// File: rtl/qvga_scan_ctrl.sv
module qvga_scan_ctrl
  import qvga_timing_pkg::*;
#(
  parameter int H_PERIOD     = 400,
  parameter int H_PULSE      = 10,
  parameter int V_PERIOD     = 255,
  parameter int V_PULSE      = 3,
  parameter int V_START      = 7,
  parameter int ACTIVE_LINES = 240,
  parameter int EN_DELAY     = 8,
  parameter int EN_WIDTH     = 320,
  parameter int CNT_W        = 9,
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [CNT_W-1:0]  cycNum,
  output logic [LINE_W-1:0] lineNum,
  output scanStrobes_t      strobes
);

  localparam logic [CNT_W-1:0]  CYC_LAST  = CNT_W'(H_PERIOD - 1);
  localparam logic [CNT_W-1:0]  HS_END    = CNT_W'(H_PULSE);
  localparam logic [CNT_W-1:0]  COL_BEG   = CNT_W'(EN_DELAY);
  localparam logic [CNT_W-1:0]  COL_END   = CNT_W'(EN_DELAY + EN_WIDTH);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(V_PERIOD - 1);
  localparam logic [LINE_W-1:0] VS_END    = LINE_W'(V_PULSE);
  localparam logic [LINE_W-1:0] ROW_BEG   = LINE_W'(V_START);
  localparam logic [LINE_W-1:0] ROW_END   = LINE_W'(V_START + ACTIVE_LINES);

  logic              lineDone;
  logic              frameDone;
  logic [CNT_W-1:0]  cycNext;
  logic [LINE_W-1:0] lineNext;

  always_comb begin
    lineDone  = (cycNum == CYC_LAST);
    frameDone = lineDone && (lineNum == LINE_LAST);
    cycNext   = lineDone ? '0 : cycNum + 1'b1;
    if (frameDone)     lineNext = '0;
    else if (lineDone) lineNext = lineNum + 1'b1;
    else               lineNext = lineNum;
  end

  // Reset parks the raster on its final position so the first edge opens a frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycNum  <= CYC_LAST;
      lineNum <= LINE_LAST;
    end else begin
      cycNum  <= cycNext;
      lineNum <= lineNext;
    end
  end

  // Decode against the next position so the registered strobes match the counters
  always_comb begin
    strobes.hsyncAct = (cycNext < HS_END);
    strobes.vsyncAct = (lineNext < VS_END);
    strobes.colAct   = (cycNext >= COL_BEG) && (cycNext < COL_END);
    strobes.rowAct   = (lineNext >= ROW_BEG) && (lineNext < ROW_END);
  end

endmodule

// File: rtl/qvga_out_stage.sv
module qvga_out_stage
  import qvga_timing_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  scanStrobes_t strobes,
  output logic         hsyncN,
  output logic         vsyncN,
  output logic         dataEn
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncN <= 1'b1;
      vsyncN <= 1'b1;
      dataEn <= 1'b0;
    end else begin
      hsyncN <= ~strobes.hsyncAct;
      vsyncN <= ~strobes.vsyncAct;
      dataEn <= strobes.colAct & strobes.rowAct;
    end
  end

endmodule

// File: rtl/qvga_panel_timing.sv
module qvga_panel_timing
  import qvga_timing_pkg::*;
#(
  parameter int H_PERIOD     = 400,
  parameter int H_PULSE      = 10,
  parameter int V_PERIOD     = 255,
  parameter int V_PULSE      = 3,
  parameter int V_START      = 7,
  parameter int ACTIVE_LINES = 240,
  parameter int EN_DELAY     = 8,
  parameter int EN_WIDTH     = 320,
  parameter int CNT_W        = 9,
  parameter int LINE_W       = 9,
  parameter bit MIRROR_H     = 1'b0,
  parameter bit FLIP_V       = 1'b1,
  parameter bit VGA_MODE     = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              hsyncN,
  output logic              vsyncN,
  output logic              dataEn,
  output logic [LINE_W-1:0] lineNum,
  output logic [CNT_W-1:0]  cycNum,
  output logic              mirrorH,
  output logic              flipV,
  output logic              vgaMode
);

  // Elaboration-time range checks on the panel timing
  if (VGA_MODE != 1'b0) begin : g_badMode
    $error("qvga_panel_timing: only the QVGA mode (0) is supported");
  end
  if (H_PERIOD < 360 || H_PERIOD > 450) begin : g_badHPeriod
    $error("qvga_panel_timing: H_PERIOD outside 360..450");
  end
  if (H_PULSE < 2 || H_PULSE > 200) begin : g_badHPulse
    $error("qvga_panel_timing: H_PULSE outside 2..200");
  end
  if (V_PERIOD < 251 || V_PERIOD > 280) begin : g_badVPeriod
    $error("qvga_panel_timing: V_PERIOD outside 251..280");
  end
  if (V_PULSE < 2 || V_PULSE > 34) begin : g_badVPulse
    $error("qvga_panel_timing: V_PULSE outside 2..34");
  end
  if (V_START != 7) begin : g_badVStart
    $error("qvga_panel_timing: V_START must be 7");
  end
  if (EN_WIDTH < 2 || EN_WIDTH > H_PERIOD - 10) begin : g_badEnWidth
    $error("qvga_panel_timing: EN_WIDTH outside 2..H_PERIOD-10");
  end
  if (EN_DELAY < 2 || EN_DELAY > H_PERIOD - 340) begin : g_badEnDelay
    $error("qvga_panel_timing: EN_DELAY outside 2..H_PERIOD-340");
  end
  if (EN_DELAY + EN_WIDTH > H_PERIOD) begin : g_badEnFit
    $error("qvga_panel_timing: enable window overruns the line");
  end
  if (ACTIVE_LINES < 1 || V_START + ACTIVE_LINES > V_PERIOD) begin : g_badRows
    $error("qvga_panel_timing: visible lines overrun the frame");
  end
  if (H_PERIOD > (1 << CNT_W) || V_PERIOD > (1 << LINE_W)) begin : g_badWidth
    $error("qvga_panel_timing: counter width too small");
  end

  scanStrobes_t strobes;

  qvga_scan_ctrl #(
    .H_PERIOD(H_PERIOD), .H_PULSE(H_PULSE), .V_PERIOD(V_PERIOD),
    .V_PULSE(V_PULSE), .V_START(V_START), .ACTIVE_LINES(ACTIVE_LINES),
    .EN_DELAY(EN_DELAY), .EN_WIDTH(EN_WIDTH), .CNT_W(CNT_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cycNum(cycNum), .lineNum(lineNum), .strobes(strobes)
  );

  qvga_out_stage u_out (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .dataEn(dataEn)
  );

  assign mirrorH = MIRROR_H;
  assign flipV   = FLIP_V;
  assign vgaMode = VGA_MODE;

endmodule

// File: rtl/qvga_timing_chk.sv
module qvga_timing_chk #(
  parameter int H_PERIOD     = 400,
  parameter int H_PULSE      = 10,
  parameter int V_PERIOD     = 255,
  parameter int V_PULSE      = 3,
  parameter int V_START      = 7,
  parameter int ACTIVE_LINES = 240,
  parameter int EN_DELAY     = 8,
  parameter int EN_WIDTH     = 320,
  parameter int CNT_W        = 9,
  parameter int LINE_W       = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              hsyncN,
  input logic              vsyncN,
  input logic              dataEn,
  input logic [LINE_W-1:0] lineNum,
  input logic [CNT_W-1:0]  cycNum
);

  localparam logic [CNT_W-1:0]  C_LAST = CNT_W'(H_PERIOD - 1);
  localparam logic [CNT_W-1:0]  C_HS   = CNT_W'(H_PULSE);
  localparam logic [CNT_W-1:0]  C_EB   = CNT_W'(EN_DELAY);
  localparam logic [CNT_W-1:0]  C_EE   = CNT_W'(EN_DELAY + EN_WIDTH);
  localparam logic [LINE_W-1:0] L_LAST = LINE_W'(V_PERIOD - 1);
  localparam logic [LINE_W-1:0] L_VS   = LINE_W'(V_PULSE);
  localparam logic [LINE_W-1:0] L_RB   = LINE_W'(V_START);
  localparam logic [LINE_W-1:0] L_RE   = LINE_W'(V_START + ACTIVE_LINES);

  logic rowIn;
  logic colIn;
  assign rowIn = (lineNum >= L_RB) && (lineNum < L_RE);
  assign colIn = (cycNum >= C_EB) && (cycNum < C_EE);

  p_cyc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cycNum != C_LAST) |=> (cycNum == $past(cycNum) + 1'b1));

  p_cyc_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cycNum == C_LAST) |=> (cycNum == '0));

  p_line_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cycNum == C_LAST && lineNum != L_LAST) |=> (lineNum == $past(lineNum) + 1'b1));

  p_line_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cycNum == C_LAST && lineNum == L_LAST) |=> (lineNum == '0));

  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cycNum != C_LAST) |=> $stable(lineNum));

  p_hsync_r4: assert property (@(posedge clk) disable iff (!rstN)
    hsyncN == (cycNum >= C_HS));

  p_vsync_r5: assert property (@(posedge clk) disable iff (!rstN)
    vsyncN == (lineNum >= L_VS));

  p_en_col_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rowIn && colIn) |-> dataEn);

  p_en_row_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> (rowIn && colIn));

endmodule

bind qvga_panel_timing qvga_timing_chk #(
  .H_PERIOD(H_PERIOD), .H_PULSE(H_PULSE), .V_PERIOD(V_PERIOD),
  .V_PULSE(V_PULSE), .V_START(V_START), .ACTIVE_LINES(ACTIVE_LINES),
  .EN_DELAY(EN_DELAY), .EN_WIDTH(EN_WIDTH), .CNT_W(CNT_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .vsyncN(vsyncN),
  .dataEn(dataEn), .lineNum(lineNum), .cycNum(cycNum)
);

// File: tb/qvga_panel_timing_test.sv
module qvga_panel_timing_test;

  localparam int HP = 400;
  localparam int HW = 10;
  localparam int VP = 255;
  localparam int VW = 3;
  localparam int VS = 7;
  localparam int AL = 240;
  localparam int ED = 8;
  localparam int EW = 320;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       hsyncN, vsyncN, dataEn, mirrorH, flipV, vgaMode;
  logic [8:0] lineNum, cycNum;

  qvga_panel_timing uut (
    .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .vsyncN(vsyncN), .dataEn(dataEn),
    .lineNum(lineNum), .cycNum(cycNum), .mirrorH(mirrorH), .flipV(flipV),
    .vgaMode(vgaMode)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nBad    = 0;
  int n       = -1;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCyc(input int k);  return k % HP; endfunction
  function automatic int expLine(input int k); return (k / HP) % VP; endfunction
  function automatic int expHs(input int k);   return (expCyc(k) < HW) ? 0 : 1; endfunction
  function automatic int expVs(input int k);   return (expLine(k) < VW) ? 0 : 1; endfunction
  function automatic int expEn(input int k);
    int c = expCyc(k);
    int l = expLine(k);
    return (c >= ED && c < ED + EW && l >= VS && l < VS + AL) ? 1 : 0;
  endfunction

  // Position counter: edges since release
  always @(posedge clk) begin
    if (!rstN) n <= -1;
    else       n <= n + 1;
  end

  // Event measurement state
  bit prevH = 1, prevV = 1, prevE = 0;
  bit haveFall = 0, haveV = 0, firstSeen = 0;
  int sinceH = 0, hLow = 0, vLines = 0, lineIdx = 0, enLines = 0, enRun = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      check("R1 hsync idle", int'(hsyncN), 1);
      check("R1 vsync idle", int'(vsyncN), 1);
      check("R1 enable idle", int'(dataEn), 0);
      check("R1 cycle parked", int'(cycNum), HP - 1);
      check("R1 line parked", int'(lineNum), VP - 1);
      check("R8 mirror", int'(mirrorH), 0);
      check("R8 flip", int'(flipV), 1);
      check("R8 mode", int'(vgaMode), 0);
      haveFall = 0; haveV = 0; firstSeen = 0;
      sinceH = 0; hLow = 0; vLines = 0; lineIdx = 0; enLines = 0; enRun = 0;
    end else if (n >= 0) begin
      if (n == 0) begin
        check("R1 first cycle", int'(cycNum), 0);
        check("R1 first line", int'(lineNum), 0);
      end
      check("R2 cycle count", int'(cycNum), expCyc(n));
      check("R3 line count", int'(lineNum), expLine(n));
      check("R4 hsync level", int'(hsyncN), expHs(n));
      check("R5 vsync level", int'(vsyncN), expVs(n));
      check("R6 enable level", int'(dataEn), expEn(n));
      if (n % 997 == 0) begin
        check("R8 mirror", int'(mirrorH), 0);
        check("R8 flip", int'(flipV), 1);
        check("R8 mode", int'(vgaMode), 0);
      end

      sinceH++;
      if (prevV && !vsyncN) begin
        if (haveV) check("R7 enabled lines per frame", enLines, AL);
        haveV = 1; enLines = 0; firstSeen = 0;
      end
      if (prevH && !hsyncN) begin
        if (haveFall) check("R2 hsync period", sinceH, HP);
        haveFall = 1; sinceH = 0; hLow = 0;
        lineIdx = (prevV && !vsyncN) ? 0 : lineIdx + 1;
        if (prevV && !vsyncN) vLines = 1;
        else if (!vsyncN) vLines++;
      end
      if (!hsyncN) hLow++;
      if (!prevH && hsyncN) check("R4 hsync width", hLow, HW);
      if (!prevV && vsyncN) check("R5 vsync width in lines", vLines, VW);
      if (!prevE && dataEn) begin
        check("R6 enable offset from hsync", sinceH, ED);
        if (!firstSeen) begin
          check("R7 first enabled line", lineIdx, VS);
          firstSeen = 1;
        end
        enLines++;
        enRun = 0;
      end
      if (dataEn) enRun++;
      if (prevE && !dataEn) check("R6 enable width", enRun, EW);
    end
    prevH = hsyncN;
    prevV = vsyncN;
    prevE = dataEn;
  end

  initial begin
    int unsigned seed;
    int unsigned runLen;
    int unsigned holdLen;
    seed = $urandom(32'd90713);
    #1 rstN = 1'b0;
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;
    runLen = 800 + ($urandom % 3000);
    repeat (runLen) @(negedge clk);
    #1 rstN = 1'b0;
    holdLen = 1 + ($urandom % 4);
    repeat (holdLen) @(negedge clk);
    #1 rstN = 1'b1;
    repeat (HP * VP + 2 * HP + 50) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule